// File: doc/BRIEF.md
# Reduced-Precision Weight-Stationary Processing Element

This block is one cell of a weight-stationary systolic multiply-accumulate array. A 5-bit compressed weight code is captured while a preload strobe is high and then stays put while signed 7-bit activations stream through the cell. On every rising edge the cell passes the incoming activation on to its right neighbour. When compute is enabled, it also registers the incoming partial sum plus the product of the rebuilt weight and the current activation, and passes that sum down.

The cell does not store a full 8-bit weight. It rebuilds the weight from the compressed code. A fixed 1 stands in for the discarded low bit, and a placement flag decides where the 4-bit signed payload sits. This keeps the multiplier about 5 bits wide on the weight side.

A build-time mode parameter turns the cell into a compensation element. In that mode the code carries a valid flag, a sign and a 3-bit residual, and an invalid code contributes nothing. The partial-sum path is sized from a parameterised count of accumulated terms.

Top module: `rp_pe`

## Requirements
- R1: While `rst_n` is low, the held weight code, `act_out` and `psum_out` are all zero.
- R2: `wt_in` is captured on a rising edge where `load_en` is 1. Otherwise the held code keeps its value, whatever `wt_in` does.
- R3: `act_out` equals the `act_in` value sampled at the previous rising edge, on every edge, whatever `en` is.
- R4: On a rising edge with `en` = 1, `psum_out` becomes signed `psum_in` + W × signed `act_in`, where W is the effective weight of the code held before that edge.
- R5: On a rising edge with `en` = 0, `psum_out` keeps its value.
- R6: In main mode (`COMP_MODE` = 0), a code with bit 4 = 0 is a compact weight. W = 2 × signed(code[3:0]) + 1, so W is odd and lies in -15..15.
- R7: In main mode, a code with bit 4 = 1 is a wide weight. W = 16 × signed(code[3:0]), so W lies in -128..112.
- R8: In compensation mode (`COMP_MODE` = 1), bit 4 is the valid flag, bit 3 is the sign and bits 2:0 are the residual. A valid code gives W = -16 × bit3 + 2 × code[2:0] + 1.
- R9: In compensation mode, a code with bit 4 = 0 gives W = 0, so `psum_out` becomes `psum_in` unchanged.
- R10: With default parameters, `psum_out` is 19 bits wide and carries the sum of 8 worst-case products (W = -128, activation = -64, total 65536) exactly.
- R11: When `load_en` and `en` are both 1 on the same edge, the product uses the previously held weight. The new code applies from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Preload strobe for the weight code |
| wt_in | input | 5 | Compressed weight code |
| en | input | 1 | Compute enable for the partial-sum register |
| act_in | input | ACT_W (7) | Signed activation from the left |
| act_out | output | ACT_W (7) | Activation forwarded to the right |
| psum_in | input | PSUM_W (19) | Signed partial sum from above |
| psum_out | output | PSUM_W (19) | Signed partial sum passed down |

## Verification
The bench builds two copies of the cell with the default widths: one with `COMP_MODE` = 0 and one with `COMP_MODE` = 1, both fed the same stimulus. Both the 5-bit code and the 7-bit activation are small, so the bench sweeps every one of the 32 × 128 weight/activation pairs in both modes. It also varies the incoming partial sum, so every rebuilt weight value and every invalid compensation code is compared against arithmetic. Beyond the sweep, the bench runs directed sequences for hold on disable, ignored weight changes, a same-edge load and compute, and an eight-deep worst-case accumulation chain.

// File: rtl/rp_pe.sv
module rp_pe #(
  parameter int ACT_W     = 7,
  parameter int MAX_TERMS = 8,
  parameter bit COMP_MODE = 1'b0,
  parameter int PSUM_W    = ACT_W + 9 + $clog2(MAX_TERMS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [4:0]               wt_in,
  input  logic                     en,
  input  logic signed [ACT_W-1:0]  act_in,
  output logic signed [ACT_W-1:0]  act_out,
  input  logic signed [PSUM_W-1:0] psum_in,
  output logic signed [PSUM_W-1:0] psum_out
);

  localparam int WEFF_W = 9;
  localparam int PROD_W = WEFF_W + ACT_W;

  logic [4:0]               wt_q;
  logic signed [WEFF_W-1:0] w_eff;
  logic signed [PROD_W-1:0] prod;
  logic                     primed;

  generate
    if (COMP_MODE) begin : g_comp
      assign w_eff = wt_q[4] ? {{5{wt_q[3]}}, wt_q[2:0], 1'b1} : '0;
    end else begin : g_main
      assign w_eff = wt_q[4] ? {wt_q[3], wt_q[3:0], 4'b0000}
                             : {{4{wt_q[3]}}, wt_q[3:0], 1'b1};
    end
  endgenerate

  assign prod = w_eff * act_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wt_q     <= '0;
      act_out  <= '0;
      psum_out <= '0;
      primed   <= 1'b0;
    end else begin
      primed  <= 1'b1;
      act_out <= act_in;
      if (load_en) wt_q <= wt_in;
      if (en) psum_out <= psum_in + PSUM_W'(prod);
    end
  end

  AST_ACT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> act_out == $past(act_in)); // R3

  AST_PSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(en)) |-> $stable(psum_out)); // R5

  AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(load_en)) |-> $stable(wt_q)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rst_n) |-> (psum_out == '0 && act_out == '0)); // R1

  generate
    if (COMP_MODE) begin : g_comp_chk
      AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wt_q[4]) |=> psum_out == $past(psum_in)); // R9
    end else begin : g_main_chk
      AST_COMPACT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wt_q[4] && act_in == 1) |=> (psum_out - $past(psum_in)) % 2 != 0); // R6
    end
  endgenerate

endmodule

// File: tb/test_rp_pe.sv
module test_rp_pe;
  localparam int ACT_W  = 7;
  localparam int PSUM_W = 19;

  logic clk = 1'b0;
  logic rst_n, load_en, en;
  logic [4:0] wt_in;
  logic signed [ACT_W-1:0]  act_in;
  logic signed [PSUM_W-1:0] psum_in;
  logic signed [ACT_W-1:0]  act_out, act_out_c;
  logic signed [PSUM_W-1:0] psum_out, psum_out_c;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rp_pe #(.COMP_MODE(1'b0)) i_rp_pe (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .wt_in(wt_in), .en(en),
    .act_in(act_in), .act_out(act_out), .psum_in(psum_in), .psum_out(psum_out));

  rp_pe #(.COMP_MODE(1'b1)) i_rp_pe_comp (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .wt_in(wt_in), .en(en),
    .act_in(act_in), .act_out(act_out_c), .psum_in(psum_in), .psum_out(psum_out_c));

  function automatic int nib(input int c);
    int n = c & 15;
    return (n > 7) ? n - 16 : n;
  endfunction

  function automatic int w_main(input int c);
    if (c & 16) return 16 * nib(c);   // R7
    return 2 * nib(c) + 1;            // R6
  endfunction

  function automatic int w_comp(input int c);
    if (!(c & 16)) return 0;          // R9
    return -16 * ((c >> 3) & 1) + 2 * (c & 7) + 1; // R8
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load(input int c);
    @(negedge clk);
    load_en = 1'b1; wt_in = 5'(c); en = 1'b0;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    rst_n = 1'b0; load_en = 1'b0; en = 1'b0; wt_in = '0; act_in = '0; psum_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 psum", int'(psum_out), 0);
    chk("R1 act", int'(act_out), 0);
    chk("R1 psum comp", int'(psum_out_c), 0);
    rst_n = 1'b1;

    // exhaustive sweep: R4, R6, R7, R8, R9, R3
    for (int c = 0; c < 32; c++) begin
      load(c);
      for (int a = -64; a < 64; a++) begin
        int p;
        p = ((a + 64) * 73 + c * 511) % 4001 - 2000;
        act_in = ACT_W'(a); psum_in = PSUM_W'(p); en = 1'b1;
        @(negedge clk);
        chk((c & 16) ? "R4/R7 main" : "R4/R6 main", int'(psum_out), p + w_main(c) * a);
        chk((c & 16) ? "R4/R8 comp" : "R9 comp", int'(psum_out_c), p + w_comp(c) * a);
        chk("R3 act", int'(act_out), a);
      end
    end

    // R5: en low holds, activation still moves
    en = 1'b0; act_in = 7'sd21; psum_in = 19'sd999;
    acc = int'(psum_out);
    @(negedge clk);
    chk("R5 hold", int'(psum_out), acc);
    chk("R3 act en low", int'(act_out), 21);

    // R2: wt_in change without load_en is ignored
    load(5'b00011);                   // W=7
    wt_in = 5'b10111;                 // would be 112
    en = 1'b1; act_in = 7'sd5; psum_in = 19'sd10;
    @(negedge clk);
    chk("R2 ignore", int'(psum_out), 10 + 7 * 5);

    // R11: load and compute on the same edge
    load_en = 1'b1; wt_in = 5'b11000; act_in = 7'sd3; psum_in = 19'sd0;
    @(negedge clk);
    chk("R11 old weight", int'(psum_out), 21);
    load_en = 1'b0;
    @(negedge clk);
    chk("R11 new weight", int'(psum_out), -384);

    // R10: eight worst-case products chained
    acc = 0;
    for (int k = 0; k < 8; k++) begin
      act_in = -7'sd64; psum_in = PSUM_W'(acc);
      @(negedge clk);
      acc = int'(psum_out);
    end
    chk("R10 chain", acc, 65536);

    // R1: reset clears after activity
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", int'(psum_out), 0);
    rst_n = 1'b1; en = 1'b1; act_in = 7'sd1; psum_in = '0;
    @(negedge clk);
    chk("R1 weight cleared", int'(psum_out), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule